// File: doc/BRIEF.md
# Nine-Bit Display Word Packer

This block sits between a byte source and an SPI master that can only shift 8-bit words. It serves a three-wire display link where every transferred word is nine bits long. Each incoming byte carries a flag that says whether it is a command (flag 0) or a parameter/pixel byte (flag 1). The block turns each tagged byte into a nine-bit word: the flag goes first, then the byte MSB first. It packs the words back to back into an 8-bit output stream, so every group of eight words leaves as exactly nine bytes.

A command always occupies the last word slot of a group. Any slots before it are filled with all-zero words, which the panel treats as no-operation. A data transfer marked as finished with its last input is completed by appending zero words until the group is full. The final byte of every closed transfer is tagged with an end marker. The SPI side can use that marker to release chip select. Both edges use valid/ready handshakes, and the output is fully registered.

Top module: `dbi9_packer`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Each accepted byte forms a nine-bit word, {flag, byte[7:0]}, sent flag first and then the byte MSB first. Words are concatenated with no gaps in the order they are accepted. The first output byte of a group is {flag0, byte0[7:1]}, so a pixel fed high byte first is sent high byte first.
- R3: Each group of eight words yields nine output bytes. When the eighth word of a group is accepted, in_ready is 0 in the following cycle while the ninth byte is loaded (given out_ready is 1).
- R4: A beat with flag 0 is a complete command transfer whatever in_last is. Zero words are inserted ahead of it until it lands in slot 7 of its group, so a command at slot 0 leaves as eight 0x00 bytes followed by the command byte. in_ready stays 0 while the padding is emitted.
- R5: A data beat (flag 1) with in_last set closes the transfer. Zero words follow it until the group holds eight words. No padding is added when the last word already fills slot 7.
- R6: out_end is 1 only on the ninth byte of a group that closes a transfer (a command, or a data beat with in_last), and 0 on every other byte.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_byte and out_end hold their values. No byte is lost or repeated.
- R8: When the output register is free, a byte accepted at a clock edge produces its first output byte with out_valid 1 right after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | DATA_W | Byte to send |
| in_dc | input | 1 | 0 = command, 1 = parameter or pixel data |
| in_last | input | 1 | Data byte closes its transfer |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | SPI master takes the output byte |
| out_byte | output | DATA_W | Packed output byte |
| out_end | output | 1 | Final byte of a closed transfer |

## Verification
An accepted byte shows up on the output register one edge later. A completed group then takes one more cycle for its ninth byte, and each padding word takes one cycle when the output is free. The bench changes inputs and samples outputs only on falling edges. It reads in_ready a nanosecond after the falling edge, so a handshake is known before the rising edge that completes it. The latency and in_ready-gap checks are taken at the first falling edge after the accepting edge. All other results are collected as output handshakes and compared byte by byte with a stream that the bench builds from bit-level word concatenation. This includes sweeps over every command value and over data lengths 1 to 17, with and without pseudo-random back-pressure.

// File: rtl/dbi9_pkg.sv
package dbi9_pkg;

  // Packer phases: accepting input, leading pads before a command,
  // trailing pads after a closed data transfer, ninth byte of a group.
  typedef enum logic [1:0] {
    PK_TAKE  = 2'd0,
    PK_LEAD  = 2'd1,
    PK_TRAIL = 2'd2,
    PK_NINTH = 2'd3
  } pk_state_e;

endpackage

// File: rtl/dbi9_merge.sv
module dbi9_merge #(
  parameter int DATA_W = 8,
  parameter int KW     = $clog2(DATA_W)
) (
  input  logic [KW-1:0]     slot,
  input  logic [DATA_W-1:0] carry_in,
  input  logic [DATA_W:0]   word,
  output logic [DATA_W-1:0] byte_out,
  output logic [DATA_W-1:0] carry_out
);

  localparam int WW = DATA_W + 1;
  localparam int XW = 2 * DATA_W + 1;

  logic [XW-1:0]     wide;
  logic [XW-1:0]     shifted;
  logic [KW:0]       sh;
  logic [DATA_W-1:0] keep;

  // carry_in holds 'slot' leftover bits right-aligned; the new word is
  // appended below them, the top DATA_W bits leave, slot+1 bits remain.
  always_comb begin
    wide    = ({{(DATA_W+1){1'b0}}, carry_in} << WW) | {{DATA_W{1'b0}}, word};
    sh      = {1'b0, slot} + 1'b1;
    shifted = wide >> sh;
    for (int i = 0; i < DATA_W; i++) begin
      keep[i] = (i <= int'(slot));
    end
    byte_out  = shifted[DATA_W-1:0];
    carry_out = wide[DATA_W-1:0] & keep;
  end

endmodule

// File: rtl/dbi9_ctrl.sv
module dbi9_ctrl
  import dbi9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KW     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_dc,
  input  logic              in_last,
  input  logic              can_load,
  output logic              in_ready,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              load_end
);

  localparam logic [KW-1:0] LAST_K = KW'(DATA_W - 1);

  pk_state_e         state;
  logic [KW-1:0]     slot;
  logic [DATA_W-1:0] carry;
  logic [DATA_W-1:0] held_cmd;
  logic              end_pend;

  logic              emit_word;
  logic              ninth;
  logic              fire;
  logic [DATA_W:0]   word;
  logic [DATA_W-1:0] m_byte;
  logic [DATA_W-1:0] m_carry;

  assign in_ready = (state == PK_TAKE) && can_load;
  assign fire     = in_valid && in_ready;

  always_comb begin
    emit_word = 1'b0;
    ninth     = 1'b0;
    word      = '0;
    case (state)
      PK_TAKE: begin
        emit_word = fire;
        if (in_dc || slot == LAST_K) word = {in_dc, in_data};
      end
      PK_LEAD: begin
        emit_word = can_load;
        if (slot == LAST_K) word = {1'b0, held_cmd};
      end
      PK_TRAIL: emit_word = can_load;
      default:  ninth     = can_load;
    endcase
  end

  dbi9_merge #(.DATA_W(DATA_W), .KW(KW)) u_merge (
    .slot      (slot),
    .carry_in  (carry),
    .word      (word),
    .byte_out  (m_byte),
    .carry_out (m_carry)
  );

  assign load      = emit_word || ninth;
  assign load_byte = ninth ? carry : m_byte;
  assign load_end  = ninth && end_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PK_TAKE;
      slot     <= '0;
      carry    <= '0;
      held_cmd <= '0;
      end_pend <= 1'b0;
    end else if (ninth) begin
      state    <= PK_TAKE;
      carry    <= '0;
      end_pend <= 1'b0;
    end else if (emit_word) begin
      carry <= m_carry;
      if (state == PK_TAKE) begin
        held_cmd <= in_data;
        end_pend <= !in_dc || in_last;
      end
      if (slot == LAST_K) begin
        slot  <= '0;
        state <= PK_NINTH;
      end else begin
        slot <= slot + 1'b1;
        if (state == PK_TAKE) begin
          if (!in_dc)       state <= PK_LEAD;
          else if (in_last) state <= PK_TRAIL;
        end
      end
    end
  end

  AST_NINTH_GAP: assert property (@(posedge clk) disable iff (rst)
    emit_word && slot == LAST_K |=> !in_ready) else $error("ninth byte gap");  // R3

  AST_CMD_LEAD_STALL: assert property (@(posedge clk) disable iff (rst)
    fire && !in_dc && slot != LAST_K |=> !in_ready) else $error("lead pad stall");  // R4

  AST_TRAIL_STALL: assert property (@(posedge clk) disable iff (rst)
    fire && in_dc && in_last |=> !in_ready) else $error("trail pad stall");  // R5

endmodule

// File: rtl/dbi9_outreg.sv
module dbi9_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              load_end,
  input  logic              out_ready,
  output logic              can_load,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_end
);

  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_end   <= 1'b0;
    end else if (can_load) begin
      out_valid <= load;
      if (load) begin
        out_byte <= load_byte;
        out_end  <= load_end;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_end))
    else $error("output not held");  // R7

endmodule

// File: rtl/dbi9_packer.sv
module dbi9_packer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_dc,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_end
);

  localparam int KW  = $clog2(DATA_W);
  localparam int WW  = DATA_W + 1;
  localparam int PCW = $clog2(WW + 1);

  logic              can_load;
  logic              load;
  logic [DATA_W-1:0] load_byte;
  logic              load_end;

  dbi9_ctrl #(.DATA_W(DATA_W), .KW(KW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_dc     (in_dc),
    .in_last   (in_last),
    .can_load  (can_load),
    .in_ready  (in_ready),
    .load      (load),
    .load_byte (load_byte),
    .load_end  (load_end)
  );

  dbi9_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_byte (load_byte),
    .load_end  (load_end),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_end   (out_end)
  );

  // Position of the current output byte inside its nine-byte group,
  // counted from output handshakes only.
  logic [PCW-1:0] opos;

  always_ff @(posedge clk) begin
    if (rst) opos <= '0;
    else if (out_valid && out_ready) opos <= (opos == PCW'(WW - 1)) ? '0 : opos + 1'b1;
  end

  AST_END_ALIGN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_end |-> opos == PCW'(WW - 1)) else $error("end misaligned");  // R6

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid) else $error("no output after accept");  // R8

endmodule

// File: tb/dbi9_packer_tb.sv
`timescale 1ns/1ps
module dbi9_packer_tb;

  localparam int D   = 8;
  localparam int CAP = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [D-1:0] in_data  = '0;
  logic         in_dc    = 1'b0;
  logic         in_last  = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [D-1:0] out_byte;
  logic         out_end;

  dbi9_packer #(.DATA_W(D)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_dc(in_dc), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_end(out_end)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [7:0] exp_b [0:CAP-1];
  logic       exp_e [0:CAP-1];
  int         exp_n = 0;
  logic [7:0] got_b [0:CAP-1];
  logic       got_e [0:CAP-1];
  int         got_n = 0;
  bit         bq[$];
  int         kpos = 0;

  bit          bp_mode = 0;
  logic [15:0] lfsr    = 16'hACE1;
  bit          stalled = 0;
  logic [7:0]  st_byte;
  logic        st_end;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Back-pressure source, changes only on falling edges.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // Output monitor: records handshakes that complete on the next rising edge.
  always begin
    @(negedge clk);
    #2;
    if (!rst) begin
      if (stalled)  // R7: a stalled byte must still be there
        chk(out_valid && out_byte == st_byte && out_end == st_end, "R7 hold",
            {out_valid, out_end, out_byte}, {1'b1, st_end, st_byte});
      stalled = out_valid && !out_ready;
      st_byte = out_byte;
      st_end  = out_end;
      if (out_valid && out_ready && got_n < CAP) begin
        got_b[got_n] = out_byte;
        got_e[got_n] = out_end;
        got_n++;
      end
    end
  end

  // Reference model: bit-level concatenation of nine-bit words.
  task automatic m_word(input logic [8:0] w, input bit fin);
    for (int i = 8; i >= 0; i--) bq.push_back(w[i]);
    kpos++;
    while (bq.size() >= 8) begin
      logic [7:0] b;
      for (int j = 7; j >= 0; j--) b[j] = bq.pop_front();
      exp_b[exp_n] = b;
      exp_e[exp_n] = 1'b0;
      exp_n++;
    end
    if (kpos == 8) begin
      kpos = 0;
      if (fin) exp_e[exp_n-1] = 1'b1;
    end
  endtask

  // Drive one beat; entered and left just after a falling edge.
  task automatic send(input logic dc, input logic [7:0] d, input logic last);
    bit acc;
    in_valid = 1'b1; in_dc = dc; in_data = d; in_last = last;
    acc = 0;
    while (!acc) begin
      #1;
      acc = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic last);
    while (kpos != 7) m_word(9'h000, 1'b0);
    m_word({1'b0, c}, 1'b1);
    send(1'b0, c, last);
  endtask

  task automatic do_data(input logic [7:0] d, input logic last);
    m_word({1'b1, d}, last && kpos == 7);
    if (last) while (kpos != 0) m_word(9'h000, kpos == 7);
    send(1'b1, d, last);
  endtask

  task automatic check_phase(input string req);
    int t;
    t = 0;
    while (got_n < exp_n && t < 20000) begin @(negedge clk); t++; end
    repeat (12) @(negedge clk);
    chk(got_n == exp_n, {req, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_b[i] == exp_b[i], req, got_b[i], exp_b[i]);
      chk(got_e[i] == exp_e[i], "R6 end", got_e[i], exp_e[i]);
    end
    got_n = 0;
    exp_n = 0;
  endtask

  task automatic data_lengths(input int seed);
    for (int len = 1; len <= 17; len++)
      for (int i = 0; i < len; i++)
        do_data(8'((len * 37 + i * 13 + seed) & 8'hFF), i == len - 1);
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    @(negedge clk);

    // R8 / R2: first byte one edge after accept, flag bit in front.
    m_word({1'b1, 8'hA5}, 1'b0);
    send(1'b1, 8'hA5, 1'b0);
    chk(out_valid == 1'b1, "R8 latency", out_valid, 1);
    chk(out_byte == 8'hD2, "R2 first byte", out_byte, 8'hD2);
    for (int i = 1; i < 8; i++) do_data(8'(8'h11 * i), i == 7);
    #1;
    chk(in_ready == 1'b0, "R3 ninth gap", in_ready, 0);
    @(negedge clk);
    check_phase("R2 stream");

    // R4: every command value, in_last alternating (ignored).
    for (int c = 0; c < 256; c++) do_cmd(8'(c), c[0]);
    check_phase("R4 commands");

    // R4: command after an open data block, then pixels high byte first.
    for (int i = 0; i < 3; i++) do_data(8'(8'h40 + i), 1'b0);
    do_cmd(8'h2C, 1'b0);
    for (int p = 0; p < 5; p++) begin
      logic [15:0] px;
      px = 16'(16'hF81F + p * 16'h0841);
      do_data(px[15:8], 1'b0);
      do_data(px[7:0], p == 4);
    end
    check_phase("R4 mid-block");

    // R5: data lengths 1..17, with and without trailing pads.
    data_lengths(3);
    check_phase("R5 lengths");

    // R7: same traffic with back-pressure.
    bp_mode = 1;
    for (int c = 0; c < 40; c++) do_cmd(8'(c * 7 + 1), 1'b1);
    data_lengths(91);
    check_phase("R7 backpressure");
    bp_mode = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule